// File: doc/BRIEF.md
# Serial Configuration Loader for a Dual Frequency Synthesizer

This block takes configuration frames from a three-wire serial link. The wires are a serial clock, a data line and a load strobe. Each frame is 23 bits long and its bits are shifted into a holding register, most significant bit first. When the load strobe rises, the held frame is copied into one of four configuration latches. The last two bits of the frame pick which latch. Two of the latches hold the reference-path word for the low-band and high-band synthesizer channels. The other two hold the feedback-divider word for each channel.

The three serial inputs run on their own timing and are not tied to the system clock. The block first passes them through a synchronizer chain on the system clock. It then detects rising edges of the serial clock and of the load strobe. The field layout inside a frame depends on its destination code. The latched fields come out as parallel ports that the synthesizer datapath uses directly:

- reference divide value, test-monitor bits and pump-current select for the reference word;
- program count, swallow count, prescaler modulus select, phase-polarity bit and monitor select for the divider word.

Top module: `ser_cfg_if`

## Requirements
- R1: While `rst` is high, every output field of all four latches is zero.
- R2: Each synchronized rising edge of `serClk` with `serLd` low shifts the value on `serDat` into the 23-bit register. The first bit sent ends up at frame position 23 and the last bit sent at position 1.
- R3: Position 1 is the channel bit: 0 means low band (A) and 1 means high band (B). Position 2 is the kind bit: 0 means reference word and 1 means divider word. The 2-bit code {position 2, position 1} therefore selects 00 = reference A, 01 = reference B, 10 = divider A and 11 = divider B.
- R4: In a reference word, the fields sit at these positions:
  - position 3 drives test bit 0 and position 4 drives test bit 1;
  - positions 5 to 18 give the 14-bit reference divide value, least significant bit at position 5;
  - position 19 is the pump-current select (1 = high current).
- R5: In a divider word, the fields sit at these positions:
  - position 3 is the monitor select, position 4 the modulus select and position 5 the phase-polarity bit;
  - positions 6 to 12 give the 7-bit swallow count, LSB at 6;
  - positions 13 to 23 give the 11-bit program count, LSB at 13.
- R6: A transfer happens only on a rising edge of `serLd`. Holding `serLd` high or lowering it does not copy the frame again.
- R7: A transfer leaves the three latches it does not address unchanged.
- R8: Serial clock edges that arrive while `serLd` is high do not alter the shift register.
- R9: When more than 23 bits are shifted before a load, only the last 23 bits form the frame.
- R10: Positions 20 to 23 of a reference word reach no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| serClk | input | 1 | Serial shift clock, asynchronous |
| serDat | input | 1 | Serial data, asynchronous |
| serLd | input | 1 | Load strobe, asynchronous |
| refDivA | output | 14 | Reference divide value, channel A |
| refTestA | output | 2 | Test-monitor bits, channel A |
| pumpHiA | output | 1 | Pump-current select, channel A |
| refDivB | output | 14 | Reference divide value, channel B |
| refTestB | output | 2 | Test-monitor bits, channel B |
| pumpHiB | output | 1 | Pump-current select, channel B |
| progCntA | output | 11 | Program count, channel A |
| swallowA | output | 7 | Swallow count, channel A |
| modSelA | output | 1 | Prescaler modulus select, channel A |
| phaseInvA | output | 1 | Phase-polarity bit, channel A |
| monSelA | output | 1 | Monitor select, channel A |
| progCntB | output | 11 | Program count, channel B |
| swallowB | output | 7 | Swallow count, channel B |
| modSelB | output | 1 | Prescaler modulus select, channel B |
| phaseInvB | output | 1 | Phase-polarity bit, channel B |
| monSelB | output | 1 | Monitor select, channel B |

## Verification
The bench sends frames to all four destinations, using field values at both ends of their ranges. After each transfer it checks that the latches it did not address are untouched. A design that decoded the channel or kind bit wrongly would write the wrong latch. One that reversed a field's bit order would show a mirrored value.

One scenario lowers the load strobe only after clocking a whole second frame in. It then pulses the strobe again. A design that keeps shifting while the strobe is high would then write a different latch. A design that transfers on level instead of edge would pick up changed contents.

Another scenario sends leading junk bits, which catches a register that is too long or that keeps the oldest bits. Setting the don't-care bits of a reference word catches a field window placed one position off.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;
  localparam int FRAME_W = 23;
  localparam int RDIV_W  = 14;
  localparam int TEST_W  = 2;
  localparam int SWAL_W  = 7;
  localparam int PROG_W  = 11;
  localparam int NUM_CH  = 2;

  // frame bit indices (position p sits at index p-1)
  localparam int CH_BIT    = 0;
  localparam int KIND_BIT  = 1;
  localparam int REF_TEST0 = 2;
  localparam int REF_RDIV0 = REF_TEST0 + TEST_W;
  localparam int REF_PUMP  = REF_RDIV0 + RDIV_W;
  localparam int DIV_MON   = 2;
  localparam int DIV_MOD   = 3;
  localparam int DIV_PHASE = 4;
  localparam int DIV_SWAL0 = 5;
  localparam int DIV_PROG0 = DIV_SWAL0 + SWAL_W;

  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic load;
  } strobe_t;

  typedef struct packed {
    logic [TEST_W-1:0] test;
    logic [RDIV_W-1:0] rdiv;
    logic              pumpHi;
  } ref_word_t;

  typedef struct packed {
    logic [PROG_W-1:0] prog;
    logic [SWAL_W-1:0] swal;
    logic              modSel;
    logic              phaseInv;
    logic              monSel;
  } div_word_t;
endpackage

// File: rtl/ser_cfg_ctrl.sv
module ser_cfg_ctrl
  import ser_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    serClk,
  input  logic    serDat,
  input  logic    serLd,
  output strobe_t stb
);
  logic [SYNC_STAGES-1:0] clkSync, datSync, ldSync;
  logic clkPrev, ldPrev;
  logic clkNow, datNow, ldNow;

  always_ff @(posedge clk) begin
    if (rst) begin
      clkSync <= '0;
      datSync <= '0;
      ldSync  <= '0;
      clkPrev <= 1'b0;
      ldPrev  <= 1'b0;
    end else begin
      clkSync <= {clkSync[SYNC_STAGES-2:0], serClk};
      datSync <= {datSync[SYNC_STAGES-2:0], serDat};
      ldSync  <= {ldSync[SYNC_STAGES-2:0], serLd};
      clkPrev <= clkNow;
      ldPrev  <= ldNow;
    end
  end

  assign clkNow = clkSync[SYNC_STAGES-1];
  assign datNow = datSync[SYNC_STAGES-1];
  assign ldNow  = ldSync[SYNC_STAGES-1];

  always_comb begin
    stb.shiftEn  = clkNow & ~clkPrev & ~ldNow;
    stb.shiftBit = datNow;
    stb.load     = ldNow & ~ldPrev;
  end
endmodule

// File: rtl/ser_cfg_dpath.sv
module ser_cfg_dpath
  import ser_cfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  strobe_t   stb,
  output ref_word_t refLat [NUM_CH],
  output div_word_t divLat [NUM_CH]
);
  logic [FRAME_W-1:0] shiftReg;
  ref_word_t refNext;
  div_word_t divNext;

  always_ff @(posedge clk) begin
    if (rst)              shiftReg <= '0;
    else if (stb.shiftEn) shiftReg <= {shiftReg[FRAME_W-2:0], stb.shiftBit};
  end

  always_comb begin
    refNext.test     = shiftReg[REF_TEST0 +: TEST_W];
    refNext.rdiv     = shiftReg[REF_RDIV0 +: RDIV_W];
    refNext.pumpHi   = shiftReg[REF_PUMP];
    divNext.monSel   = shiftReg[DIV_MON];
    divNext.modSel   = shiftReg[DIV_MOD];
    divNext.phaseInv = shiftReg[DIV_PHASE];
    divNext.swal     = shiftReg[DIV_SWAL0 +: SWAL_W];
    divNext.prog     = shiftReg[DIV_PROG0 +: PROG_W];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic chHit;
    assign chHit = stb.load && (shiftReg[CH_BIT] == (g == 1));
    always_ff @(posedge clk) begin
      if (rst) begin
        refLat[g] <= '0;
        divLat[g] <= '0;
      end else if (chHit) begin
        if (shiftReg[KIND_BIT]) divLat[g] <= divNext;
        else                    refLat[g] <= refNext;
      end
    end
  end
endmodule

// File: rtl/ser_cfg_if.sv
module ser_cfg_if
  import ser_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        serClk,
  input  logic        serDat,
  input  logic        serLd,
  output logic [13:0] refDivA,
  output logic [1:0]  refTestA,
  output logic        pumpHiA,
  output logic [13:0] refDivB,
  output logic [1:0]  refTestB,
  output logic        pumpHiB,
  output logic [10:0] progCntA,
  output logic [6:0]  swallowA,
  output logic        modSelA,
  output logic        phaseInvA,
  output logic        monSelA,
  output logic [10:0] progCntB,
  output logic [6:0]  swallowB,
  output logic        modSelB,
  output logic        phaseInvB,
  output logic        monSelB
);
  strobe_t   stb;
  ref_word_t refLat [NUM_CH];
  div_word_t divLat [NUM_CH];

  ser_cfg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .serClk(serClk), .serDat(serDat), .serLd(serLd), .stb(stb)
  );

  ser_cfg_dpath u_dpath (
    .clk(clk), .rst(rst), .stb(stb), .refLat(refLat), .divLat(divLat)
  );

  assign refDivA   = refLat[0].rdiv;
  assign refTestA  = refLat[0].test;
  assign pumpHiA   = refLat[0].pumpHi;
  assign refDivB   = refLat[1].rdiv;
  assign refTestB  = refLat[1].test;
  assign pumpHiB   = refLat[1].pumpHi;
  assign progCntA  = divLat[0].prog;
  assign swallowA  = divLat[0].swal;
  assign modSelA   = divLat[0].modSel;
  assign phaseInvA = divLat[0].phaseInv;
  assign monSelA   = divLat[0].monSel;
  assign progCntB  = divLat[1].prog;
  assign swallowB  = divLat[1].swal;
  assign modSelB   = divLat[1].modSel;
  assign phaseInvB = divLat[1].phaseInv;
  assign monSelB   = divLat[1].monSel;
endmodule

// File: rtl/ser_cfg_chk.sv
module ser_cfg_chk (
  input logic        clk,
  input logic        rst,
  input logic        serClk,
  input logic        serDat,
  input logic        serLd,
  input logic [13:0] refDivA,
  input logic [1:0]  refTestA,
  input logic        pumpHiA,
  input logic [13:0] refDivB,
  input logic [1:0]  refTestB,
  input logic        pumpHiB,
  input logic [10:0] progCntA,
  input logic [6:0]  swallowA,
  input logic        modSelA,
  input logic        phaseInvA,
  input logic        monSelA,
  input logic [10:0] progCntB,
  input logic [6:0]  swallowB,
  input logic        modSelB,
  input logic        phaseInvB,
  input logic        monSelB
);
  logic [16:0] grpRefA, grpRefB;
  logic [20:0] grpDivA, grpDivB;
  assign grpRefA = {refDivA, refTestA, pumpHiA};
  assign grpRefB = {refDivB, refTestB, pumpHiB};
  assign grpDivA = {progCntA, swallowA, modSelA, phaseInvA, monSelA};
  assign grpDivB = {progCntB, swallowB, modSelB, phaseInvB, monSelB};

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (grpRefA == '0 && grpRefB == '0 && grpDivA == '0 && grpDivB == '0));

  // R7
  one_group_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({!$stable(grpRefA), !$stable(grpRefB), !$stable(grpDivA), !$stable(grpDivB)}) <= 1);

  // R6
  quiet_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!serLd && !$past(serLd) && !$past(serLd, 2) && !$past(serLd, 3))
      |=> ($stable(grpRefA) && $stable(grpRefB) && $stable(grpDivA) && $stable(grpDivB)));

  // R6
  change_needs_load_chk: assert property (@(posedge clk) disable iff (rst)
    !($stable(grpRefA) && $stable(grpRefB) && $stable(grpDivA) && $stable(grpDivB))
      |-> $past(serLd, 2));
endmodule

bind ser_cfg_if ser_cfg_chk u_chk (.*);

// File: tb/ser_cfg_if_tb.sv
module ser_cfg_if_tb;
  logic clk = 0, rst = 1, serClk = 0, serDat = 0, serLd = 0;
  logic [13:0] refDivA, refDivB;
  logic [1:0]  refTestA, refTestB;
  logic        pumpHiA, pumpHiB;
  logic [10:0] progCntA, progCntB;
  logic [6:0]  swallowA, swallowB;
  logic        modSelA, phaseInvA, monSelA, modSelB, phaseInvB, monSelB;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ser_cfg_if u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(input logic [31:0] w, input int cnt);
    for (int i = cnt - 1; i >= 0; i--) begin
      serDat = w[i];
      waitClk(3);
      serClk = 1;
      waitClk(3);
      serClk = 0;
      waitClk(2);
    end
  endtask

  task automatic pulseLoad();
    serLd = 1;
    waitClk(5);
    serLd = 0;
    waitClk(5);
  endtask

  function automatic logic [22:0] refWord(input bit ch, input logic [1:0] t,
      input logic [13:0] r, input bit cs, input logic [3:0] dc);
    return {dc, cs, r, t, 1'b0, ch};
  endfunction

  function automatic logic [22:0] divWord(input bit ch, input logic [10:0] n,
      input logic [6:0] a, input bit fc, input bit sw, input bit lds);
    return {n, a, fc, sw, lds, 1'b1, ch};
  endfunction

  task automatic t_reset();
    chk("R1 refDivA", refDivA, 0);
    chk("R1 refDivB", refDivB, 0);
    chk("R1 progCntA", progCntA, 0);
    chk("R1 swallowB", swallowB, 0);
    chk("R1 bits", {pumpHiA, pumpHiB, monSelA, monSelB, modSelA, phaseInvB}, 0);
  endtask

  task automatic t_refA();
    sendBits(refWord(0, 2'b01, 14'd3, 1, 4'h0), 23);
    pulseLoad();
    chk("R4 refDivA", refDivA, 3);
    chk("R4 refTestA", refTestA, 2'b01);
    chk("R4 pumpHiA", pumpHiA, 1);
    chk("R7 R3 refDivB untouched", refDivB, 0);
    chk("R7 R3 progCntA untouched", progCntA, 0);
  endtask

  task automatic t_refB();
    sendBits(refWord(1, 2'b10, 14'd16383, 0, 4'hF), 23);
    pulseLoad();
    chk("R3 R4 refDivB", refDivB, 16383);
    chk("R4 refTestB", refTestB, 2'b10);
    chk("R10 pumpHiB", pumpHiB, 0);
    chk("R10 progCntB", {progCntB, swallowB}, 0);
    chk("R7 refDivA kept", refDivA, 3);
  endtask

  task automatic t_divA();
    sendBits(divWord(0, 11'd1234, 7'd77, 1, 0, 1), 23);
    pulseLoad();
    chk("R5 progCntA", progCntA, 1234);
    chk("R5 swallowA", swallowA, 77);
    chk("R5 flagsA", {phaseInvA, modSelA, monSelA}, 3'b101);
    chk("R7 refA kept", {refDivA, refTestA, pumpHiA}, {14'd3, 2'b01, 1'b1});
  endtask

  task automatic t_divB();
    sendBits(divWord(1, 11'd2047, 7'd0, 0, 1, 0), 23);
    pulseLoad();
    chk("R3 R5 progCntB", progCntB, 2047);
    chk("R5 swallowB", swallowB, 0);
    chk("R5 flagsB", {phaseInvB, modSelB, monSelB}, 3'b010);
    chk("R7 divA kept", progCntA, 1234);
  endtask

  task automatic t_loadHeld();
    sendBits(refWord(0, 2'b11, 14'd500, 0, 4'h5), 23);
    serLd = 1;
    waitClk(5);
    sendBits(divWord(1, 11'd9, 7'd9, 1, 1, 1), 23);
    serLd = 0;
    waitClk(5);
    chk("R6 refDivA once", refDivA, 500);
    chk("R6 R8 progCntB unchanged", progCntB, 2047);
    pulseLoad();
    chk("R8 refDivA reload", refDivA, 500);
    chk("R8 divB kept", {progCntB, swallowB}, {11'd2047, 7'd0});
  endtask

  task automatic t_overlong();
    sendBits(32'h1F, 5);
    sendBits(divWord(0, 11'd5, 7'd127, 0, 1, 0), 23);
    pulseLoad();
    chk("R9 R2 progCntA", progCntA, 5);
    chk("R9 R2 swallowA", swallowA, 127);
    chk("R9 flagsA", {phaseInvA, modSelA, monSelA}, 3'b010);
  endtask

  initial begin
    waitClk(4);
    t_reset();
    rst = 0;
    waitClk(3);
    t_refA();
    t_refB();
    t_divA();
    t_divB();
    t_loadHeld();
    t_overlong();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule